// File: doc/BRIEF.md
# Vector Compare to Predicate Mask Unit

This unit runs a conditional-branch encoding as a compare over every element of a vector register. It never branches. For each element it makes one comparison and stores the outcome as a single bit of a predicate word, at the bit position equal to the element index. Both the 32-bit branch layout and a reinterpreted 16-bit layout are accepted. In both layouts the field that would normally hold the branch offset names the predicate register that receives the mask.

The issue logic pulses `start_i` with the instruction word, the vector length and the two packed source vectors. It also says whether the destination register is tagged as a predicate register. The unit then handles one element per clock. When it finishes it raises `done_o` for one cycle, together with the mask, the destination register index and either a write enable or an illegal flag.

A destination that is not tagged behaves like an ordinary scalar compare. Only element 0 is examined, and the whole word reads 1 when the condition holds and 0 when it does not. Greater-or-equal has no encoding of its own. It is produced by swapping the operands of a less-or-equal compare.

Top module: `vcp_unit`

## Requirements
- R1: When `is_c_i` is 0, the word is accepted if bits 6:0 equal 1100011. Funct3 (bits 14:12) selects the compare: 000 equal, 001 not-equal, 100 signed less-than, 101 signed greater-or-equal. The predicate register index is taken from bits 11:7.
- R2: Signed greater-or-equal (funct3 101) yields, for each element, the result of b <= a with operands a and b swapped.
- R3: A 32-bit word is illegal if any reserved bit 31:25 is set, if funct3 is any value other than those in R1, or if the opcode is wrong. An illegal operation raises `illegal_o` with `done_o` on the first cycle after start. `pred_we_o` stays 0, so the predicate register is left unchanged.
- R4: When `is_c_i` is 1, only bits 15:0 are used. Bits 1:0 must be 01 and bits 15:13 must be 110 or 111. The compare is chosen by {bit 13, bit 5}: 00 equal, 01 not-equal, 10 signed less-than, 11 signed less-or-equal. The predicate register index is 8 plus bits 12:10.
- R5: A 16-bit word with bit 6 set (float compare) is illegal, and so is one with a wrong quadrant or funct3. Such a word is handled as in R3.
- R6: With `pred_tag_i` = 1, bit i of `pred_o` holds the result for element i, for every i below the vector length. All higher bits are 0. Element i sits at bits [i*ELEM_W +: ELEM_W] of each vector, as a two's-complement value. A length of 0 is treated as 1, and a length above MAX_VL is treated as MAX_VL.
- R7: With `pred_tag_i` = 0, only element 0 is compared, and `pred_o` is 1 when the condition holds and 0 when it does not.
- R8: The unit makes one comparison per cycle. For a legal operation over n elements, `done_o` and `pred_we_o` are high for exactly one cycle, n+1 cycles after the start edge. `busy_o` is high from the start edge until `done_o` falls.
- R9: A `start_i` pulse that arrives while `busy_o` is high is ignored. No extra result is produced, and the running result is not altered.
- R10: After reset, `busy_o`, `done_o`, `pred_we_o` and `illegal_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch request, sampled when idle |
| is_c_i | input | 1 | 1 selects the 16-bit layout in insn_i[15:0] |
| insn_i | input | 32 | Instruction word |
| vl_i | input | 7 | Vector length (1..MAX_VL) |
| pred_tag_i | input | 1 | Destination is tagged as a predicate register |
| vec_a_i | input | MAX_VL*ELEM_W | Source vector 1, held stable while busy |
| vec_b_i | input | MAX_VL*ELEM_W | Source vector 2, held stable while busy |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| pred_we_o | output | 1 | Write the predicate word (legal operation) |
| illegal_o | output | 1 | Operation rejected |
| pred_idx_o | output | 5 | Destination predicate register index |
| pred_o | output | MAX_VL | Predicate mask |

## Verification
Some properties are checked by assertions on every cycle. `done_o` is a single-cycle pulse. A write and an illegal flag never appear together. The element index never passes the last element. Mask bits above the length are clear at completion. An untagged result never has any bit other than bit 0 set. A start during a run never disturbs the latched length or tag, and greater-or-equal always decodes with swapped operands. Other behaviours can only be shown by the bench scenarios. These are the actual mask values for each compare, signed against unsigned ordering at the extreme values, the field positions of the register index in both layouts, the exact completion latency, length clamping, and the absence of a second result when start is repeated mid-run.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_NE = 2'b01,
    CMP_LT = 2'b10,
    CMP_LE = 2'b11
  } cmp_op_e;

  typedef struct packed {
    cmp_op_e    op;
    logic       swap;
    logic       bad;
    logic [4:0] preg;
  } dec_t;

  localparam logic [6:0] BR_OPCODE = 7'b1100011;
  localparam logic [1:0] C_QUAD1   = 2'b01;

endpackage

// File: rtl/vcp_decode.sv
module vcp_decode
  import vcp_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic        is_c_i,
  output dec_t        dec_o
);

  logic [2:0] f3_w;
  logic [2:0] f3_c;

  assign f3_w = insn_i[14:12];
  assign f3_c = insn_i[15:13];

  always_comb begin
    dec_o      = '0;
    dec_o.bad  = 1'b1;
    dec_o.op   = CMP_EQ;
    if (is_c_i) begin
      dec_o.preg = {2'b01, insn_i[12:10]};
      unique case ({insn_i[13], insn_i[5]})
        2'b00:   dec_o.op = CMP_EQ;
        2'b01:   dec_o.op = CMP_NE;
        2'b10:   dec_o.op = CMP_LT;
        default: dec_o.op = CMP_LE;
      endcase
      if ((insn_i[1:0] == C_QUAD1) && (f3_c[2:1] == 2'b11) && !insn_i[6]) begin
        dec_o.bad = 1'b0;
      end
    end else begin
      dec_o.preg = insn_i[11:7];
      dec_o.bad  = 1'b0;
      unique case (f3_w)
        3'b000:  dec_o.op = CMP_EQ;
        3'b001:  dec_o.op = CMP_NE;
        3'b100:  dec_o.op = CMP_LT;
        3'b101: begin
          dec_o.op   = CMP_LE;
          dec_o.swap = 1'b1;
        end
        default: dec_o.bad = 1'b1;
      endcase
      if ((insn_i[6:0] != BR_OPCODE) || (insn_i[31:25] != 7'd0)) begin
        dec_o.bad = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vcp_elem_cmp.sv
module vcp_elem_cmp
  import vcp_pkg::*;
#(
  parameter int ELEM_W = 16
) (
  input  logic [ELEM_W-1:0] a_i,
  input  logic [ELEM_W-1:0] b_i,
  input  cmp_op_e           op_i,
  input  logic              swap_i,
  output logic              res_o
);

  logic signed [ELEM_W-1:0] lhs;
  logic signed [ELEM_W-1:0] rhs;
  logic                     eq_w;
  logic                     lt_w;

  always_comb begin
    lhs = swap_i ? $signed(b_i) : $signed(a_i);
    rhs = swap_i ? $signed(a_i) : $signed(b_i);
  end

  assign eq_w = (lhs == rhs);
  assign lt_w = (lhs < rhs);

  always_comb begin
    unique case (op_i)
      CMP_EQ:  res_o = eq_w;
      CMP_NE:  res_o = !eq_w;
      CMP_LT:  res_o = lt_w;
      default: res_o = lt_w || eq_w;
    endcase
  end

endmodule

// File: rtl/vcp_seq.sv
module vcp_seq
  import vcp_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int CNT_W  = $clog2(MAX_VL + 1),
  parameter int IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  vl_i,
  input  logic              tag_i,
  input  dec_t              dec_i,
  input  logic              cmp_res_i,
  output dec_t              dec_q_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              we_o,
  output logic              illegal_o,
  output logic [MAX_VL-1:0] pred_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  st_e                st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [IDX_W-1:0]   last_q, last_d;
  logic [MAX_VL-1:0]  acc_q, acc_d;
  dec_t               dec_q, dec_d;
  logic               tag_q, tag_d;
  logic [CNT_W-1:0]   vl_clamp;
  logic               accept;

  always_comb begin
    if (vl_i == '0) begin
      vl_clamp = CNT_W'(1);
    end else if (vl_i > CNT_W'(MAX_VL)) begin
      vl_clamp = CNT_W'(MAX_VL);
    end else begin
      vl_clamp = vl_i;
    end
  end

  assign accept = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    last_d = last_q;
    acc_d  = acc_q;
    dec_d  = dec_q;
    tag_d  = tag_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          dec_d  = dec_i;
          tag_d  = tag_i;
          idx_d  = '0;
          acc_d  = '0;
          last_d = tag_i ? IDX_W'(vl_clamp - CNT_W'(1)) : '0;
          st_d   = dec_i.bad ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        acc_d[idx_q] = cmp_res_i;
        if (idx_q == last_q) begin
          st_d = ST_FIN;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      acc_q  <= '0;
      dec_q  <= '0;
      tag_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      acc_q <= acc_d;
      if (accept) begin
        last_q <= last_d;
        dec_q  <= dec_d;
        tag_q  <= tag_d;
      end
    end
  end

  assign dec_q_o   = dec_q;
  assign idx_o     = idx_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_FIN);
  assign we_o      = done_o && !dec_q.bad;
  assign illegal_o = done_o && dec_q.bad;
  assign pred_o    = acc_q;

  logic [MAX_VL-1:0] hi_mask;
  always_comb begin
    for (int i = 0; i < MAX_VL; i++) begin
      hi_mask[i] = (i > int'(last_q));
    end
  end

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_we_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (we_o != illegal_o));

  p_idx_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> (idx_q <= last_q));

  p_hi_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && tag_q) |-> ((acc_q & hi_mask) == '0));

  p_untag_bit0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !tag_q) |-> ((acc_q >> 1) == '0));

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(last_q) && $stable(tag_q) && $stable(dec_q)));

endmodule

// File: rtl/vcp_unit.sv
module vcp_unit
  import vcp_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int ELEM_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     is_c_i,
  input  logic [31:0]              insn_i,
  input  logic [6:0]               vl_i,
  input  logic                     pred_tag_i,
  input  logic [MAX_VL*ELEM_W-1:0] vec_a_i,
  input  logic [MAX_VL*ELEM_W-1:0] vec_b_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     pred_we_o,
  output logic                     illegal_o,
  output logic [4:0]               pred_idx_o,
  output logic [MAX_VL-1:0]        pred_o
);

  localparam int CNT_W = $clog2(MAX_VL + 1);
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  dec_t dec_w;
  dec_t dec_q;

  vcp_decode u_dec (
    .insn_i (insn_i),
    .is_c_i (is_c_i),
    .dec_o  (dec_w)
  );

  logic [ELEM_W-1:0] elem_a [MAX_VL];
  logic [ELEM_W-1:0] elem_b [MAX_VL];

  for (genvar g = 0; g < MAX_VL; g++) begin : g_unpack
    assign elem_a[g] = vec_a_i[g*ELEM_W +: ELEM_W];
    assign elem_b[g] = vec_b_i[g*ELEM_W +: ELEM_W];
  end

  logic [IDX_W-1:0]  idx_w;
  logic [ELEM_W-1:0] a_sel;
  logic [ELEM_W-1:0] b_sel;
  logic              res_w;

  assign a_sel = elem_a[idx_w];
  assign b_sel = elem_b[idx_w];

  vcp_elem_cmp #(.ELEM_W(ELEM_W)) u_cmp (
    .a_i    (a_sel),
    .b_i    (b_sel),
    .op_i   (dec_q.op),
    .swap_i (dec_q.swap),
    .res_o  (res_w)
  );

  vcp_seq #(.MAX_VL(MAX_VL), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .start_i   (start_i),
    .vl_i      (CNT_W'(vl_i)),
    .tag_i     (pred_tag_i),
    .dec_i     (dec_w),
    .cmp_res_i (res_w),
    .dec_q_o   (dec_q),
    .idx_o     (idx_w),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .we_o      (pred_we_o),
    .illegal_o (illegal_o),
    .pred_o    (pred_o)
  );

  assign pred_idx_o = dec_q.preg;

  p_ge_swaps_r2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (!is_c_i && (insn_i[14:12] == 3'b101) && !dec_w.bad) |-> (dec_w.swap && dec_w.op == CMP_LE));

  p_resv_bad_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (!is_c_i && (insn_i[31:25] != 7'd0)) |-> dec_w.bad);

  p_float_bad_r5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (is_c_i && insn_i[6]) |-> dec_w.bad);

endmodule

// File: tb/vcp_unit_tb_top.sv
module vcp_unit_tb_top;

  localparam int MAX_VL = 64;
  localparam int EW     = 16;

  logic                  clk;
  logic                  rst_n;
  logic                  start;
  logic                  is_c;
  logic [31:0]           insn;
  logic [6:0]            vl;
  logic                  tag;
  logic [MAX_VL*EW-1:0]  vec_a;
  logic [MAX_VL*EW-1:0]  vec_b;
  logic                  busy, done, we, ill;
  logic [4:0]            pidx;
  logic [MAX_VL-1:0]     pred;

  logic signed [EW-1:0]  va [MAX_VL];
  logic signed [EW-1:0]  vb [MAX_VL];

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  logic [MAX_VL-1:0] q_pred [$];
  logic [6:0]        q_flag [$];
  string             q_req  [$];

  vcp_unit #(.MAX_VL(MAX_VL), .ELEM_W(EW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .is_c_i(is_c),
    .insn_i(insn), .vl_i(vl), .pred_tag_i(tag), .vec_a_i(vec_a),
    .vec_b_i(vec_b), .busy_o(busy), .done_o(done), .pred_we_o(we),
    .illegal_o(ill), .pred_idx_o(pidx), .pred_o(pred)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < MAX_VL; i++) begin
      vec_a[i*EW +: EW] = va[i];
      vec_b[i*EW +: EW] = vb[i];
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a result strobe appears
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_req.size() == 0) begin
        chk(1'b0, "R9 unexpected result", 1, 0);
      end else begin
        logic [MAX_VL-1:0] ep;
        logic [6:0]        ef;
        string             r;
        ep = q_pred.pop_front();
        ef = q_flag.pop_front();
        r  = q_req.pop_front();
        chk(we == ef[6] && ill == ef[5], {r, " flags"}, {we, ill}, ef[6:5]);
        if (ef[6]) begin
          chk(pred == ep, {r, " mask"}, pred, ep);
          chk(pidx == ef[4:0], {r, " index"}, pidx, ef[4:0]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic bit ref_cmp(int op, logic signed [EW-1:0] a, logic signed [EW-1:0] b);
    case (op)
      0: return a == b;
      1: return a != b;
      2: return a < b;
      3: return a <= b;
      default: return a >= b;
    endcase
  endfunction

  function automatic logic [31:0] w32(logic [2:0] f3, logic [4:0] pr, logic [6:0] rsv, logic [6:0] opc);
    return {rsv, 5'd2, 5'd1, f3, pr, opc};
  endfunction

  function automatic logic [31:0] w16(logic [2:0] f3, logic [2:0] pr, logic fl, logic ext, logic [1:0] q);
    return {16'hffff, f3, pr, 3'd1, fl, ext, 3'd2, q};
  endfunction

  // op: 0 EQ, 1 NE, 2 LT, 3 LE, 4 GE, -1 illegal
  task automatic run_op(input logic [31:0] w, input bit c, input int n_in, input bit tg,
                        input int op, input logic [4:0] epr, input string req, input bit disturb);
    int n;
    int lat;
    logic [MAX_VL-1:0] ep;
    n = (n_in < 1) ? 1 : (n_in > MAX_VL ? MAX_VL : n_in);
    if (!tg) n = 1;
    ep = '0;
    for (int i = 0; i < n; i++) ep[i] = ref_cmp(op, va[i], vb[i]);
    q_pred.push_back(ep);
    q_flag.push_back({op >= 0, op < 0, epr});
    q_req.push_back(req);
    chk(!busy, "R8 idle before start", busy, 0);
    insn = w; is_c = c; vl = 7'(n_in); tag = tg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      if (disturb && lat == 2) begin
        start = 1'b1; insn = w32(3'b001, 5'd30, 7'd0, 7'b1100011); vl = 7'd3; tag = ~tg;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk(lat == ((op < 0) ? 1 : n + 1), {req, " R8 latency"}, lat, (op < 0) ? 1 : n + 1);
    @(negedge clk);
    chk(!done && !busy, {req, " R8 strobe one cycle"}, done, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; is_c = 1'b0; insn = '0; vl = 7'd1; tag = 1'b0;
    for (int i = 0; i < MAX_VL; i++) begin
      va[i] = EW'(((i * 37) % 200) - 100);
      if (i % 5 == 0)      vb[i] = va[i];
      else if (i % 3 == 0) vb[i] = va[i] + 16'sd1;
      else                 vb[i] = va[i] - 16'sd3;
    end
    va[63] = 16'sh7fff; vb[63] = 16'sh8000;
    va[40] = 16'sh8000; vb[40] = 16'sh0001;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !we && !ill, "R10 reset outputs", {busy, done, we, ill}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !we && !ill, "R10 after release", {busy, done, we, ill}, 0);

    run_op(w32(3'b000, 5'd5,  7'd0, 7'b1100011), 0, 16, 1, 0, 5'd5,  "R1 R6 eq", 0);
    run_op(w32(3'b001, 5'd17, 7'd0, 7'b1100011), 0, 64, 1, 1, 5'd17, "R1 R6 ne full", 0);
    run_op(w32(3'b100, 5'd31, 7'd0, 7'b1100011), 0, 64, 1, 2, 5'd31, "R1 lt signed", 0);
    run_op(w32(3'b101, 5'd3,  7'd0, 7'b1100011), 0, 64, 1, 4, 5'd3,  "R2 ge swap", 0);
    run_op(w32(3'b100, 5'd9,  7'd0, 7'b1100011), 0, 20, 0, 2, 5'd9,  "R7 untagged lt", 0);
    run_op(w32(3'b000, 5'd9,  7'd0, 7'b1100011), 0, 20, 0, 0, 5'd9,  "R7 untagged eq", 0);
    run_op(w32(3'b000, 5'd1,  7'h40, 7'b1100011), 0, 8, 1, -1, 5'd1, "R3 reserved bits", 0);
    run_op(w32(3'b010, 5'd1,  7'd0, 7'b1100011), 0, 8, 1, -1, 5'd1,  "R3 bad funct3", 0);
    run_op(w32(3'b000, 5'd1,  7'd0, 7'b0010011), 0, 8, 1, -1, 5'd1,  "R3 bad opcode", 0);
    run_op(w16(3'b110, 3'd2, 0, 0, 2'b01), 1, 12, 1, 0, 5'd10, "R4 c eq", 0);
    run_op(w16(3'b110, 3'd7, 0, 1, 2'b01), 1, 12, 1, 1, 5'd15, "R4 c ne", 0);
    run_op(w16(3'b111, 3'd0, 0, 0, 2'b01), 1, 45, 1, 2, 5'd8,  "R4 c lt", 0);
    run_op(w16(3'b111, 3'd5, 0, 1, 2'b01), 1, 64, 1, 3, 5'd13, "R4 c le", 0);
    run_op(w16(3'b110, 3'd2, 1, 0, 2'b01), 1, 12, 1, -1, 5'd10, "R5 float bit", 0);
    run_op(w16(3'b110, 3'd2, 0, 0, 2'b10), 1, 12, 1, -1, 5'd10, "R5 bad quadrant", 0);
    run_op(w16(3'b100, 3'd2, 0, 0, 2'b01), 1, 12, 1, -1, 5'd10, "R5 bad funct3", 0);
    run_op(w32(3'b001, 5'd6,  7'd0, 7'b1100011), 0, 1,   1, 1, 5'd6, "R6 length one", 0);
    run_op(w32(3'b001, 5'd6,  7'd0, 7'b1100011), 0, 0,   1, 1, 5'd6, "R6 length zero", 0);
    run_op(w32(3'b001, 5'd6,  7'd0, 7'b1100011), 0, 100, 1, 1, 5'd6, "R6 length clamp", 0);
    run_op(w32(3'b100, 5'd12, 7'd0, 7'b1100011), 0, 8,   1, 2, 5'd12, "R9 start while busy", 1);

    repeat (5) @(negedge clk);
    chk(q_req.size() == 0, "R9 scoreboard drained", q_req.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule